// File: doc/BRIEF.md
# Configuration Image Header Parser

This block sits in front of a device-programming engine and consumes a configuration image one byte at a time over a valid/ready handshake. It first confirms a fixed 13-byte leading signature. It then walks four length-prefixed information sections (name, target part, date, time). For each section it records the stream offset of the first content byte and the content length. After that it expects an 'e' tag followed by a 32-bit big-endian payload length.

Once the header is accepted, the parser forwards exactly that many payload bytes to a downstream consumer over a second valid/ready stream. It then raises `done`. Any byte that breaks the expected layout moves the parser to a sticky error state, and nothing more is ever forwarded. The header phase never stalls the source. During the payload phase, the downstream ready signal paces the source.

Top module: `cfg_hdr_parser`

## Requirements
- R1: After synchronous reset, `error`, `done`, `header_ok`, `busy` and `out_valid` are 0, `pay_len` is 0 and `in_ready` is 1.
- R2: The first 13 accepted bytes must be, in order, 00 09 0F F0 0F F0 0F F0 0F F0 00 00 01 (hex). A mismatching byte sets `error` in the cycle after it is accepted, and no payload is forwarded.
- R3: Four information sections follow the signature. Each is an unchecked tag byte, a 2-byte big-endian length and that many content bytes. For section i, `sect_off[32*i +: 32]` holds the 0-based stream index of its first content byte, and `sect_len[16*i +: 16]` holds its length.
- R4: A section whose length is zero is legal; the byte right after its length field is taken as the next tag.
- R5: The byte after the fourth section must be 0x65; any other value sets `error`.
- R6: The four bytes after 0x65 form `pay_len`, most significant byte first. `header_ok` rises in the cycle after the last of them, and `pay_len` holds from then on.
- R7: Exactly `pay_len` bytes are forwarded in order on `out_data`, unchanged. `done` rises in the cycle after the last one is handed over.
- R8: If `pay_len` is 0, `done` rises right after the length field and no byte is forwarded.
- R9: Before the payload phase, `in_ready` is always 1. During the payload phase, an input byte is accepted only when `out_ready` is 1.
- R10: After `done`, input bytes are still accepted but are dropped; `out_valid` stays 0 and `done` stays 1.
- R11: `error` stays set until reset; later bytes are accepted and dropped, and `header_ok` and `done` stay 0.
- R12: `busy` is 1 from the first accepted byte until `done` or `error` is set, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Parser can take the input byte |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Payload byte valid |
| out_ready | input | 1 | Downstream can take a payload byte |
| out_data | output | 8 | Payload byte |
| pay_len | output | 32 | Payload length from the header |
| sect_off | output | NSECT*OFF_W | Per-section offset of first content byte |
| sect_len | output | NSECT*16 | Per-section content length |
| busy | output | 1 | Parsing in progress |
| header_ok | output | 1 | Header fully accepted |
| error | output | 1 | Sticky format error |
| done | output | 1 | Payload fully forwarded |

## Verification
The bound checker watches the cycle-level rules on every clock. A signature or tag fault must show up as `error` one cycle later. `error` and `done` must stay set. Payload must never appear before the header is accepted. The header phase must never deassert `in_ready`, and a stalled output must block input. `pay_len` must hold once accepted, and `busy` must not overlap the final flags. The directed scenarios show what a per-cycle property cannot: the recorded section offsets and lengths, including zero and multi-hundred-byte sections, byte-exact payload contents and counts under random-looking back-pressure, the zero-length payload case, and that trailing bytes after completion or failure produce no output.

// File: rtl/cfg_hdr_pkg.sv
`timescale 1ns/1ps
package cfg_hdr_pkg;

  localparam int SIG_LEN   = 13;
  localparam int SIG_IDX_W = $clog2(SIG_LEN);
  localparam int SLEN_W    = 16;
  localparam int PLEN_W    = 32;
  localparam int PLEN_NB   = PLEN_W / 8;
  localparam int PIDX_W    = $clog2(PLEN_NB);
  localparam logic [7:0] LEN_TAG = 8'h65;

  typedef enum logic [3:0] {
    PH_SIG,
    PH_TAG,
    PH_LHI,
    PH_LLO,
    PH_BODY,
    PH_ETAG,
    PH_PLEN,
    PH_PAY,
    PH_DONE,
    PH_ERR
  } phase_t;

  // Expected value of leading signature byte i.
  function automatic logic [7:0] sig_byte(input logic [SIG_IDX_W-1:0] i);
    logic [7:0] v;
    case (i)
      4'd1:                     v = 8'h09;
      4'd2, 4'd4, 4'd6, 4'd8:   v = 8'h0F;
      4'd3, 4'd5, 4'd7, 4'd9:   v = 8'hF0;
      4'd12:                    v = 8'h01;
      default:                  v = 8'h00;
    endcase
    return v;
  endfunction

  // Big-endian 16-bit join of a stored high byte and the current byte.
  function automatic logic [SLEN_W-1:0] be_join16(input logic [7:0] hi, input logic [7:0] lo);
    return {hi, lo};
  endfunction

  // Shift one byte into a big-endian 32-bit accumulator.
  function automatic logic [PLEN_W-1:0] be_push32(input logic [PLEN_W-1:0] cur, input logic [7:0] b);
    return {cur[PLEN_W-9:0], b};
  endfunction

endpackage

// File: rtl/hdr_sig_check.sv
`timescale 1ns/1ps
module hdr_sig_check
  import cfg_hdr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       step,
  input  logic [7:0] din,
  output logic       mismatch,
  output logic       at_last
);

  logic [SIG_IDX_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst)                  idx <= '0;
    else if (step && !at_last) idx <= idx + 1'b1;
  end

  assign mismatch = (din != sig_byte(idx));
  assign at_last  = (idx == SIG_IDX_W'(SIG_LEN - 1));

endmodule

// File: rtl/hdr_down_counter.sv
`timescale 1ns/1ps
module hdr_down_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         last
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                    cnt <= '0;
    else if (load)              cnt <= load_val;
    else if (dec && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign last = (cnt == W'(1));

endmodule

// File: rtl/cfg_hdr_parser.sv
`timescale 1ns/1ps
module cfg_hdr_parser
  import cfg_hdr_pkg::*;
#(
  parameter int NSECT = 4,
  parameter int OFF_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [7:0]              in_data,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [7:0]              out_data,
  output logic [PLEN_W-1:0]       pay_len,
  output logic [NSECT*OFF_W-1:0]  sect_off,
  output logic [NSECT*SLEN_W-1:0] sect_len,
  output logic                    busy,
  output logic                    header_ok,
  output logic                    error,
  output logic                    done
);

  localparam int SIDX_W = (NSECT > 1) ? $clog2(NSECT) : 1;

  phase_t st, st_d;

  logic              acc;
  logic              sig_bad, sig_last, tag_bad;
  logic              body_last, pay_last;
  logic              sect_end, sect_rec, hdr_fire;
  logic              last_sect;
  logic [SIDX_W-1:0] sidx;
  logic [PIDX_W-1:0] pidx;
  logic [7:0]        slen_hi;
  logic [SLEN_W-1:0] slen_now;
  logic [PLEN_W-1:0] plen_q, plen_now;
  logic [OFF_W-1:0]  pos;
  logic              started, hok_q;

  // Handshake and pass-through
  assign in_ready  = (st == PH_PAY) ? out_ready : 1'b1;
  assign acc       = in_valid && in_ready;
  assign out_valid = (st == PH_PAY) && in_valid;
  assign out_data  = in_data;

  // Named events
  assign slen_now  = be_join16(slen_hi, in_data);
  assign plen_now  = be_push32(plen_q, in_data);
  assign last_sect = (sidx == SIDX_W'(NSECT - 1));
  assign tag_bad   = acc && (st == PH_ETAG) && (in_data != LEN_TAG);
  assign sect_rec  = acc && (st == PH_LLO);
  assign sect_end  = (sect_rec && slen_now == '0) || (acc && st == PH_BODY && body_last);
  assign hdr_fire  = acc && (st == PH_PLEN) && (pidx == PIDX_W'(PLEN_NB - 1));

  logic sig_miss;
  hdr_sig_check u_sig (
    .clk     (clk),
    .rst     (rst),
    .step    (acc && st == PH_SIG),
    .din     (in_data),
    .mismatch(sig_miss),
    .at_last (sig_last)
  );
  assign sig_bad = acc && (st == PH_SIG) && sig_miss;

  hdr_down_counter #(.W(SLEN_W)) u_body (
    .clk     (clk),
    .rst     (rst),
    .load    (sect_rec),
    .load_val(slen_now),
    .dec     (acc && st == PH_BODY),
    .last    (body_last)
  );

  hdr_down_counter #(.W(PLEN_W)) u_pay (
    .clk     (clk),
    .rst     (rst),
    .load    (hdr_fire),
    .load_val(plen_now),
    .dec     (acc && st == PH_PAY),
    .last    (pay_last)
  );

  // Phase sequencing
  always_comb begin
    st_d = st;
    if (acc) begin
      case (st)
        PH_SIG:  if (sig_miss) st_d = PH_ERR;
                 else if (sig_last) st_d = PH_TAG;
        PH_TAG:  st_d = PH_LHI;
        PH_LHI:  st_d = PH_LLO;
        PH_LLO:  if (slen_now == '0) st_d = last_sect ? PH_ETAG : PH_TAG;
                 else st_d = PH_BODY;
        PH_BODY: if (body_last) st_d = last_sect ? PH_ETAG : PH_TAG;
        PH_ETAG: st_d = (in_data == LEN_TAG) ? PH_PLEN : PH_ERR;
        PH_PLEN: if (pidx == PIDX_W'(PLEN_NB - 1))
                   st_d = (plen_now == '0) ? PH_DONE : PH_PAY;
        PH_PAY:  if (pay_last) st_d = PH_DONE;
        default: st_d = st;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= PH_SIG;
      sidx    <= '0;
      pidx    <= '0;
      slen_hi <= '0;
      plen_q  <= '0;
      pos     <= '0;
      started <= 1'b0;
      hok_q   <= 1'b0;
    end else begin
      st <= st_d;
      if (acc) started <= 1'b1;
      if (acc && st != PH_PAY && st != PH_DONE && st != PH_ERR) pos <= pos + 1'b1;
      if (acc && st == PH_LHI) slen_hi <= in_data;
      if (sect_end && !last_sect) sidx <= sidx + 1'b1;
      if (acc && st == PH_PLEN) begin
        plen_q <= plen_now;
        pidx   <= pidx + 1'b1;
      end
      if (hdr_fire) hok_q <= 1'b1;
    end
  end

  // Per-section records
  for (genvar g = 0; g < NSECT; g++) begin : g_sect
    logic [OFF_W-1:0]  off_q;
    logic [SLEN_W-1:0] len_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        off_q <= '0;
        len_q <= '0;
      end else if (sect_rec && sidx == SIDX_W'(g)) begin
        off_q <= pos + 1'b1;
        len_q <= slen_now;
      end
    end
    assign sect_off[g*OFF_W  +: OFF_W]  = off_q;
    assign sect_len[g*SLEN_W +: SLEN_W] = len_q;
  end

  assign pay_len   = plen_q;
  assign header_ok = hok_q;
  assign error     = (st == PH_ERR);
  assign done      = (st == PH_DONE);
  assign busy      = started && !error && !done;

endmodule

// File: rtl/cfg_hdr_parser_chk.sv
`timescale 1ns/1ps
module cfg_hdr_parser_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] pay_len,
  input logic        busy,
  input logic        header_ok,
  input logic        error,
  input logic        done,
  input logic        sig_bad,
  input logic        tag_bad
);

  AST_SIG_FAULT:   assert property (@(posedge clk) disable iff (rst) sig_bad |=> error);                        // R2
  AST_ETAG_FAULT:  assert property (@(posedge clk) disable iff (rst) tag_bad |=> error);                        // R5
  AST_LEN_HOLD:    assert property (@(posedge clk) disable iff (rst) header_ok |=> $stable(pay_len));           // R6
  AST_NO_EARLY_OUT: assert property (@(posedge clk) disable iff (rst) out_valid |-> (header_ok && !done && !error)); // R7
  AST_HDR_READY:   assert property (@(posedge clk) disable iff (rst) (!header_ok && !error) |-> in_ready);      // R9
  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (rst) (out_valid && !out_ready) |-> !in_ready);  // R9
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst) done |=> (done && !out_valid));            // R10
  AST_ERR_STICKY:  assert property (@(posedge clk) disable iff (rst) error |=> (error && !header_ok && !done)); // R11
  AST_BUSY_EXCL:   assert property (@(posedge clk) disable iff (rst) busy |-> (!done && !error));              // R12

endmodule

bind cfg_hdr_parser cfg_hdr_parser_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .pay_len  (pay_len),
  .busy     (busy),
  .header_ok(header_ok),
  .error    (error),
  .done     (done),
  .sig_bad  (sig_bad),
  .tag_bad  (tag_bad)
);

// File: tb/sim_cfg_hdr_parser.sv
`timescale 1ns/1ps
module sim_cfg_hdr_parser;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [7:0]   in_data = '0;
  logic         out_ready = 1'b1;
  logic         in_ready, out_valid, busy, header_ok, error, done;
  logic [7:0]   out_data;
  logic [31:0]  pay_len;
  logic [127:0] sect_off;
  logic [63:0]  sect_len;

  cfg_hdr_parser u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .pay_len(pay_len),
    .sect_off(sect_off), .sect_len(sect_len), .busy(busy), .header_ok(header_ok),
    .error(error), .done(done)
  );

  int nchk = 0, nfail = 0;
  logic [7:0] img [0:1023];
  int ilen;
  logic [7:0] exp_pay [0:511];
  int elen;
  logic [7:0] got [0:511];
  int gcnt;
  int exp_off [4];
  int exp_len [4];
  bit bp_en = 1'b0;
  int bp_ph = 0;
  int stall_seen, bp_viol, hdr_stall;

  task automatic chk(input bit c, input string rq, input longint act, input longint exp);
    nchk++;
    if (!c) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // Downstream pacing
  always @(negedge clk) begin
    bp_ph = (bp_ph + 1) % 5;
    out_ready <= bp_en ? (bp_ph != 1 && bp_ph != 3) : 1'b1;
  end

  // Output and handshake monitor
  always @(negedge clk) begin
    #1;
    if (!rst) begin
      if (out_valid && out_ready && gcnt < 512) begin
        got[gcnt] = out_data;
        gcnt++;
      end
      if (out_valid && !out_ready && !in_ready) stall_seen++;
      if (out_valid && !out_ready && in_ready) bp_viol++;
      if (!header_ok && !error && in_valid && !in_ready) hdr_stall++;
    end
  end

  function automatic logic [7:0] tb_sig(input int k);
    logic [7:0] t [13] = '{8'h00, 8'h09, 8'h0F, 8'hF0, 8'h0F, 8'hF0, 8'h0F,
                           8'hF0, 8'h0F, 8'hF0, 8'h00, 8'h00, 8'h01};
    return t[k];
  endfunction

  task automatic put(input logic [7:0] b);
    img[ilen] = b;
    ilen++;
  endtask

  task automatic put_sig(input int bad_at, input logic [7:0] bad_val);
    for (int k = 0; k < 13; k++) put((k == bad_at) ? bad_val : tb_sig(k));
  endtask

  task automatic put_sect(input int i, input int n);
    put(8'(8'h61 + i));
    put(8'(n >> 8));
    put(8'(n));
    exp_off[i] = ilen;
    exp_len[i] = n;
    for (int k = 0; k < n; k++) put(8'(i * 31 + k));
  endtask

  task automatic put_plen(input logic [7:0] tag, input logic [31:0] n);
    put(tag);
    put(n[31:24]); put(n[23:16]); put(n[15:8]); put(n[7:0]);
  endtask

  task automatic put_pay(input int n, input int seed);
    for (int k = 0; k < n; k++) begin
      put(8'(seed + k * 7));
      exp_pay[elen] = 8'(seed + k * 7);
      elen++;
    end
  endtask

  task automatic push(input logic [7:0] b);
    bit ok;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    #1;
    ok = in_ready;
    while (!ok) begin
      @(negedge clk);
      #1;
      ok = in_ready;
    end
    @(posedge clk);
  endtask

  task automatic stream(input int from, input int upto);
    for (int k = from; k < upto; k++) push(img[k]);
  endtask

  task automatic settle();
    @(negedge clk);
    in_valid = 1'b0;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    gcnt = 0; ilen = 0; elen = 0;
    stall_seen = 0; bp_viol = 0; hdr_stall = 0;
    #1;
  endtask

  task automatic t_reset();
    do_reset();
    chk(!error && !done && !header_ok && !busy, "R1 flags", {error, done, header_ok, busy}, 0);
    chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    chk(!out_valid && pay_len == 0, "R1 outputs", pay_len, 0);
  endtask

  task automatic t_normal();
    int hdr_end;
    do_reset();
    put_sig(-1, 8'h00);
    put_sect(0, 3); put_sect(1, 0); put_sect(2, 5); put_sect(3, 2);
    put_plen(8'h65, 32'd6);
    hdr_end = ilen;
    put_pay(6, 8'h40);
    stream(0, 13);
    settle();
    chk(!error && busy, "R2 signature accepted", error, 0);
    stream(13, hdr_end);
    settle();
    chk(header_ok == 1'b1, "R6 header_ok", header_ok, 1);
    chk(pay_len == 32'd6, "R6 pay_len", pay_len, 6);
    chk(busy && !done, "R12 busy in payload", busy, 1);
    for (int i = 0; i < 4; i++) begin
      chk(sect_off[32*i +: 32] == 32'(exp_off[i]), "R3 offset", sect_off[32*i +: 32], exp_off[i]);
      chk(sect_len[16*i +: 16] == 16'(exp_len[i]), "R3 length", sect_len[16*i +: 16], exp_len[i]);
    end
    chk(sect_len[31:16] == 0 && sect_off[63:32] == 32'(exp_off[1]), "R4 zero section", sect_off[63:32], exp_off[1]);
    stream(hdr_end, ilen);
    settle();
    chk(gcnt == 6, "R7 count", gcnt, 6);
    for (int k = 0; k < 6; k++) chk(got[k] == exp_pay[k], "R7 data", got[k], exp_pay[k]);
    chk(done && !busy && !error, "R7 done", done, 1);
    for (int k = 0; k < 5; k++) push(8'hA0 + 8'(k));
    settle();
    chk(gcnt == 6 && done && !out_valid, "R10 trailing dropped", gcnt, 6);
    chk(hdr_stall == 0, "R9 header never stalls", hdr_stall, 0);
  endtask

  task automatic t_badsig(input int at, input logic [7:0] v);
    do_reset();
    put_sig(at, v);
    put_sect(0, 1); put_sect(1, 1); put_sect(2, 1); put_sect(3, 1);
    put_plen(8'h65, 32'd4);
    put_pay(4, 3);
    stream(0, at + 1);
    settle();
    chk(error == 1'b1, "R2 mismatch flagged", error, 1);
    chk(!busy, "R12 busy after error", busy, 0);
    stream(at + 1, ilen);
    settle();
    chk(error && !header_ok && !done, "R11 error sticky", error, 1);
    chk(gcnt == 0, "R11 no output after error", gcnt, 0);
  endtask

  task automatic t_badtag();
    do_reset();
    put_sig(-1, 8'h00);
    put_sect(0, 2); put_sect(1, 2); put_sect(2, 0); put_sect(3, 4);
    put_plen(8'h66, 32'd3);
    put_pay(3, 9);
    stream(0, ilen);
    settle();
    chk(error && !header_ok, "R5 wrong length tag", error, 1);
    chk(gcnt == 0, "R5 nothing forwarded", gcnt, 0);
  endtask

  task automatic t_zero_pay();
    do_reset();
    put_sig(-1, 8'h00);
    put_sect(0, 0); put_sect(1, 0); put_sect(2, 0); put_sect(3, 0);
    put_plen(8'h65, 32'd0);
    put(8'h55); put(8'h66);
    stream(0, ilen - 2);
    settle();
    chk(done && header_ok && !error, "R8 immediate done", done, 1);
    chk(sect_off[127:96] == 32'(exp_off[3]), "R4 all-zero sections", sect_off[127:96], exp_off[3]);
    stream(ilen - 2, ilen);
    settle();
    chk(gcnt == 0 && done, "R8 nothing forwarded", gcnt, 0);
  endtask

  task automatic t_backpressure();
    do_reset();
    bp_en = 1'b1;
    put_sig(-1, 8'h00);
    put_sect(0, 1); put_sect(1, 2); put_sect(2, 1); put_sect(3, 260);
    put_plen(8'h65, 32'h0000_0028);
    put_pay(40, 8'h11);
    stream(0, ilen);
    settle();
    bp_en = 1'b0;
    chk(sect_len[63:48] == 16'd260, "R3 long section", sect_len[63:48], 260);
    chk(pay_len == 32'd40, "R6 pay_len", pay_len, 40);
    chk(gcnt == 40, "R7 count under stall", gcnt, 40);
    for (int k = 0; k < 40; k++) chk(got[k] == exp_pay[k], "R7 data under stall", got[k], exp_pay[k]);
    chk(stall_seen > 0, "R9 stall observed", stall_seen, 1);
    chk(bp_viol == 0, "R9 no accept while stalled", bp_viol, 0);
    chk(hdr_stall == 0, "R9 header ignores out_ready", hdr_stall, 0);
    chk(done && !busy, "R7 done after stall", done, 1);
  endtask

  initial begin
    #(200000 * 4);
    nchk++;
    nfail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    t_reset();
    t_normal();
    t_badsig(7, 8'h0F);
    t_badsig(0, 8'h01);
    t_badsig(12, 8'h00);
    t_badtag();
    t_zero_pay();
    t_backpressure();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule